// File: doc/BRIEF.md
# Dual-width packet-filter ALU

This block is the integer execution stage of a small packet-filter virtual machine. It takes the current destination register value, a second operand and an operation code, and returns the new destination value. The destination is also the first source, so every result has the form dest OP operand. The second operand is either a source register or a 32-bit signed immediate, which is widened by sign extension. A mode flag selects full 64-bit arithmetic or 32-bit arithmetic on the low halves. A 32-bit result is zero-filled in the upper word.

Besides the usual arithmetic, logic and shift operations, the unit has three more kinds of operation. It can do sign-extending moves from 8, 16 or 32 bits. It can convert the destination to a chosen byte order, where the result depends on the machine byte order fixed by a parameter. It can also byte-swap the destination without any condition. Inputs are captured on a clock edge while the valid input is high, and the result and a divide-by-zero flag appear on the registered outputs one cycle later. The register file, instruction decode and memory access are outside the block.

Top module: `dw_alu`

## Requirements
- R1: While rst_n is low, out_valid, rd_out and div_zero are all 0.
- R2: When use_imm is 1, the operand is imm sign-extended to 64 bits and rs_val is ignored. When use_imm is 0, the operand is rs_val.
- R3: With wide=1, op codes 0 ADD, 1 SUB, 2 MUL (low 64 bits), 5 AND, 6 OR, 7 XOR, 11 NEG (0 minus dest, operand unused) and 12 MOV (operand) give the 64-bit result of dest OP operand, with wrap-around.
- R4: With wide=0, op codes 0 to 13 use only the low 32 bits of the dest and the operand, and rd_out[63:32] is 0.
- R5: Op codes 8 (left shift), 9 (logical right shift) and 10 (arithmetic right shift) shift the dest by the operand masked to 6 bits when wide=1 and to 5 bits when wide=0.
- R6: Op codes 3 (unsigned divide) and 4 (unsigned remainder) work at the width set by wide. A zero divisor gives 0 for divide and the unchanged dest for remainder, at that width. div_zero is 1 exactly when op is 3 or 4 and the divisor is zero at that width.
- R7: Op 13 sign-extends the low 8, 16 or 32 bits of the operand (size 0, 1 or 2) to 64 bits (wide=1) or to 32 bits (wide=0). Size 3 is a plain move.
- R8: Op 14 converts the dest to big-endian order (to_big=1) or little-endian order (to_big=0), at a width of 16 bits (size 0 or 1), 32 bits (size 2) or 64 bits (size 3). If the requested order equals the BIG_ENDIAN parameter, the result is the low bits of the dest, zero-extended. Otherwise the bytes are reversed within that width and zero-extended. wide is ignored.
- R9: Op 15 always reverses the byte order of the low 16, 32 or 64 bits of the dest (size coded as in R8) and zero-extends the result.
- R10: When in_valid is high at a rising edge, rd_out and div_zero show that operation's result after that edge, and out_valid is 1. When in_valid is low at a rising edge, out_valid is 0 and rd_out and div_zero hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture an operation on this edge |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| use_imm | input | 1 | Select immediate as operand |
| rd_val | input | 64 | Destination register value (first source) |
| rs_val | input | 64 | Source register value |
| imm | input | 32 | Signed immediate |
| size | input | 2 | Width select for ops 13 to 15 |
| to_big | input | 1 | Target byte order for op 14 |
| out_valid | output | 1 | Result registered this cycle |
| rd_out | output | 64 | New destination value |
| div_zero | output | 1 | Divide or remainder by zero |

## Verification
The sweep covers every op code, both widths, all four size codes, both byte-order targets and both operand sources. Each combination runs over pairs of dest and operand patterns. The patterns are zero, one, all ones, a lone sign bit, a mixed-byte word, a small shift count and a word whose sign bit sits only in the low half. Together they separate signed from unsigned handling, 32-bit from 64-bit masking, and swap from truncate. The zero operand and an immediate whose selected bits are zero test the divide-by-zero rules at both widths. Cycles with in_valid low and changed inputs show that the outputs hold.

// File: rtl/dw_alu.sv
module dw_alu #(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [3:0]  op,
  input  logic        wide,
  input  logic        use_imm,
  input  logic [63:0] rd_val,
  input  logic [63:0] rs_val,
  input  logic [31:0] imm,
  input  logic [1:0]  size,
  input  logic        to_big,
  output logic        out_valid,
  output logic [63:0] rd_out,
  output logic        div_zero
);
  localparam int XLEN  = 64;
  localparam int HLEN  = XLEN / 2;
  localparam int NBYTE = XLEN / 8;

  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_MUL = 4'd2, OP_DIV = 4'd3,
                         OP_MOD = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
                         OP_LSH = 4'd8, OP_RSH = 4'd9, OP_ARS = 4'd10, OP_NEG = 4'd11,
                         OP_MOV = 4'd12, OP_MSX = 4'd13, OP_END = 4'd14, OP_SWP = 4'd15;

  logic [XLEN-1:0] b64;
  logic [HLEN-1:0] a32, b32;
  logic [5:0]      sh64;
  logic [4:0]      sh32;
  logic            bz64, bz32, bz;

  assign b64  = use_imm ? {{HLEN{imm[HLEN-1]}}, imm} : rs_val;
  assign a32  = rd_val[HLEN-1:0];
  assign b32  = b64[HLEN-1:0];
  assign sh64 = b64[5:0];
  assign sh32 = b32[4:0];
  assign bz64 = (b64 == '0);
  assign bz32 = (b32 == '0);
  assign bz   = wide ? bz64 : bz32;

  logic [XLEN-1:0] r64;
  always_comb begin
    case (op)
      OP_ADD:  r64 = rd_val + b64;
      OP_SUB:  r64 = rd_val - b64;
      OP_MUL:  r64 = rd_val * b64;
      OP_DIV:  r64 = bz64 ? '0 : rd_val / b64;
      OP_MOD:  r64 = bz64 ? rd_val : rd_val % b64;
      OP_AND:  r64 = rd_val & b64;
      OP_OR:   r64 = rd_val | b64;
      OP_XOR:  r64 = rd_val ^ b64;
      OP_LSH:  r64 = rd_val << sh64;
      OP_RSH:  r64 = rd_val >> sh64;
      OP_ARS:  r64 = $unsigned($signed(rd_val) >>> sh64);
      OP_NEG:  r64 = '0 - rd_val;
      default: r64 = b64;
    endcase
  end

  logic [HLEN-1:0] r32;
  always_comb begin
    case (op)
      OP_ADD:  r32 = a32 + b32;
      OP_SUB:  r32 = a32 - b32;
      OP_MUL:  r32 = a32 * b32;
      OP_DIV:  r32 = bz32 ? '0 : a32 / b32;
      OP_MOD:  r32 = bz32 ? a32 : a32 % b32;
      OP_AND:  r32 = a32 & b32;
      OP_OR:   r32 = a32 | b32;
      OP_XOR:  r32 = a32 ^ b32;
      OP_LSH:  r32 = a32 << sh32;
      OP_RSH:  r32 = a32 >> sh32;
      OP_ARS:  r32 = $unsigned($signed(a32) >>> sh32);
      OP_NEG:  r32 = '0 - a32;
      default: r32 = b32;
    endcase
  end

  logic [XLEN-1:0] sx64;
  always_comb begin
    case (size)
      2'd0:    sx64 = {{(XLEN-8){b64[7]}}, b64[7:0]};
      2'd1:    sx64 = {{(XLEN-16){b64[15]}}, b64[15:0]};
      2'd2:    sx64 = {{HLEN{b64[HLEN-1]}}, b64[HLEN-1:0]};
      default: sx64 = b64;
    endcase
  end

  logic [XLEN-1:0] rev64, sw_res, tr_res, bo_res;
  for (genvar i = 0; i < NBYTE; i++) begin : g_rev
    assign rev64[8*i +: 8] = rd_val[XLEN-1-8*i -: 8];
  end

  always_comb begin
    case (size)
      2'd2:    begin
                 sw_res = {{HLEN{1'b0}}, rev64[XLEN-1 -: HLEN]};
                 tr_res = {{HLEN{1'b0}}, rd_val[HLEN-1:0]};
               end
      2'd3:    begin
                 sw_res = rev64;
                 tr_res = rd_val;
               end
      default: begin
                 sw_res = {{(XLEN-16){1'b0}}, rev64[XLEN-1 -: 16]};
                 tr_res = {{(XLEN-16){1'b0}}, rd_val[15:0]};
               end
    endcase
  end

  assign bo_res = (op == OP_SWP || to_big != BIG_ENDIAN) ? sw_res : tr_res;

  logic [XLEN-1:0] res;
  always_comb begin
    if (op == OP_END || op == OP_SWP) res = bo_res;
    else if (op == OP_MSX)            res = wide ? sx64 : {{HLEN{1'b0}}, sx64[HLEN-1:0]};
    else                              res = wide ? r64 : {{HLEN{1'b0}}, r32};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rd_out    <= '0;
      div_zero  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        rd_out   <= res;
        div_zero <= (op == OP_DIV || op == OP_MOD) && bz;
      end
    end
  end
endmodule

// File: rtl/dw_alu_sva.sv
module dw_alu_sva #(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  op,
  input logic        wide,
  input logic        use_imm,
  input logic [63:0] rd_val,
  input logic [63:0] rs_val,
  input logic [31:0] imm,
  input logic [1:0]  size,
  input logic        to_big,
  input logic        out_valid,
  input logic [63:0] rd_out,
  input logic        div_zero
);
  logic [63:0] opnd;
  logic        zdiv;
  assign opnd = use_imm ? {{32{imm[31]}}, imm} : rs_val;
  assign zdiv = wide ? (opnd == 64'd0) : (opnd[31:0] == 32'd0);

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(rd_out) && $stable(div_zero)));
  assert_div_by_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd3 && zdiv) |=> (div_zero && rd_out == 64'd0));
  assert_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 4'd3 && op != 4'd4) |=> !div_zero);
  assert_upper_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide && op <= 4'd13) |=> (rd_out[63:32] == 32'd0));
  assert_end_truncate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd14 && size == 2'd1 && to_big == BIG_ENDIAN)
      |=> (rd_out == {48'd0, $past(rd_val[15:0])}));
  assert_swap16_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd15 && size == 2'd1)
      |=> (rd_out == {48'd0, $past(rd_val[7:0]), $past(rd_val[15:8])}));
endmodule

bind dw_alu dw_alu_sva #(.BIG_ENDIAN(BIG_ENDIAN)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
  .use_imm(use_imm), .rd_val(rd_val), .rs_val(rs_val), .imm(imm), .size(size),
  .to_big(to_big), .out_valid(out_valid), .rd_out(rd_out), .div_zero(div_zero)
);

// File: tb/dw_alu_tb.sv
`timescale 1ns/1ps
module dw_alu_tb;
  localparam bit BIG = 1'b0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        wide = 1'b0;
  logic        use_imm = 1'b0;
  logic [63:0] rd_val = '0;
  logic [63:0] rs_val = '0;
  logic [31:0] imm = '0;
  logic [1:0]  size = '0;
  logic        to_big = 1'b0;
  logic        out_valid;
  logic [63:0] rd_out;
  logic        div_zero;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dw_alu #(.BIG_ENDIAN(BIG)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
    .use_imm(use_imm), .rd_val(rd_val), .rs_val(rs_val), .imm(imm), .size(size),
    .to_big(to_big), .out_valid(out_valid), .rd_out(rd_out), .div_zero(div_zero)
  );

  function automatic logic [63:0] pat(input int k);
    case (k)
      0: return 64'd0;
      1: return 64'd1;
      2: return 64'hFFFF_FFFF_FFFF_FFFF;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h0123_4567_89AB_CDEF;
      5: return 64'h0000_0000_8000_0041;
      6: return 64'hFEDC_BA98_7654_3210;
      default: return 64'd3;
    endcase
  endfunction

  function automatic logic [63:0] byterev(input logic [63:0] x, input int n);
    logic [63:0] y = '0;
    for (int i = 0; i < n; i++) y = (y << 8) | ((x >> (8 * i)) & 64'hFF);
    return y;
  endfunction

  function automatic logic [63:0] sext(input logic [63:0] x, input int bits);
    logic [63:0] m = (bits == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << bits) - 1);
    logic [63:0] v = x & m;
    if (bits < 64 && v[bits-1]) v = v - (64'd1 << bits);
    return v;
  endfunction

  function automatic logic [63:0] ars(input logic [63:0] x, input int s, input int w);
    logic [63:0] m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF;
    logic [63:0] v = (x & m) >> s;
    if (x[w-1]) v = v | (m & ~(m >> s));
    return v;
  endfunction

  function automatic void model(input logic [3:0] o, input logic w, input logic [1:0] sz,
                                input logic tb_, input logic ui, input logic [63:0] d,
                                input logic [63:0] s, input logic [31:0] im,
                                output logic [63:0] r, output logic dz);
    logic [63:0] b = ui ? sext({32'd0, im}, 32) : s;
    int wd = w ? 64 : 32;
    logic [63:0] m = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF;
    logic [63:0] a = d & m;
    logic [63:0] bb = b & m;
    int sh = int'(bb & 64'(wd - 1));
    int nb = (sz == 2'd3) ? 8 : (sz == 2'd2) ? 4 : 2;
    dz = 1'b0;
    case (o)
      4'd0: r = a + bb;
      4'd1: r = a - bb;
      4'd2: r = a * bb;
      4'd3: begin dz = (bb == 0); r = dz ? 64'd0 : a / bb; end
      4'd4: begin dz = (bb == 0); r = dz ? a : a % bb; end
      4'd5: r = a & bb;
      4'd6: r = a | bb;
      4'd7: r = a ^ bb;
      4'd8: r = a << sh;
      4'd9: r = a >> sh;
      4'd10: r = ars(a, sh, wd);
      4'd11: r = 64'd0 - a;
      4'd12: r = bb;
      4'd13: r = (sz == 2'd3) ? bb : sext(b, 8 << sz);
      4'd14: r = (tb_ == BIG) ? (d & ((nb == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * nb)) - 1)))
                              : byterev(d, nb);
      default: r = byterev(d, nb);
    endcase
    if (o <= 4'd13) r = r & m;
  endfunction

  function automatic string tag(input logic [3:0] o, input logic w, input logic ui);
    string t;
    if (o == 4'd3 || o == 4'd4) t = "R6";
    else if (o >= 4'd8 && o <= 4'd10) t = "R5";
    else if (o == 4'd13) t = "R7";
    else if (o == 4'd14) t = "R8";
    else if (o == 4'd15) t = "R9";
    else t = "R3";
    if (!w && o <= 4'd13) t = {t, "+R4"};
    if (ui && o <= 4'd13) t = {t, "+R2"};
    return t;
  endfunction

  task automatic chk64(input string t, input logic [63:0] act, input logic [63:0] exp_);
    checks++;
    if (act !== exp_) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp_);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [63:0] er;
    logic ez;
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    op = 4'd0; rd_val = 64'h55; rs_val = 64'h66;
    @(negedge clk);
    chk64("R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk64("R1 rd_out", rd_out, 64'd0);
    chk64("R1 div_zero", {63'd0, div_zero}, 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int o = 0; o < 16; o++)
      for (int w = 0; w < 2; w++)
        for (int sz = 0; sz < 4; sz++)
          for (int tb_ = 0; tb_ < 2; tb_++)
            for (int ui = 0; ui < 2; ui++)
              for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++) begin
                  op = 4'(o); wide = w[0]; size = 2'(sz); to_big = tb_[0]; use_imm = ui[0];
                  rd_val = pat(i); rs_val = pat(j); imm = pat(j)[39:8];
                  in_valid = 1'b1;
                  model(op, wide, size, to_big, use_imm, rd_val, rs_val, imm, er, ez);
                  @(negedge clk);
                  chk64(tag(op, wide, use_imm), rd_out, er);
                  chk64("R6 div_zero", {63'd0, div_zero}, {63'd0, ez});
                  chk64("R10 out_valid", {63'd0, out_valid}, 64'd1);
                  if (i == 4 && j == 6 && sz == 0 && tb_ == 0 && ui == 0) begin
                    in_valid = 1'b0;
                    rd_val = ~rd_val; rs_val = 64'd0; op = 4'd3;
                    @(negedge clk);
                    chk64("R10 hold rd_out", rd_out, er);
                    chk64("R10 hold div_zero", {63'd0, div_zero}, {63'd0, ez});
                    chk64("R10 idle out_valid", {63'd0, out_valid}, 64'd0);
                  end
                end

    in_valid = 1'b0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule